// File: doc/BRIEF.md
# Dual-Width Read-Only Memory Port

This block models a small read-only array of 16-bit words that a host can read either as whole words or as single bytes. A mode input chooses the width on every access. In word mode the address bus selects one stored word and all sixteen data lanes carry it. In byte mode an extra address bit comes in on a dedicated input that shares its pad with data lane 15. That bit picks one half of the addressed word, and only the low eight lanes are driven. Each data lane has its own drive-enable bit, which stands in for a tri-state pad. A lane whose enable is low is undriven.

Reads are registered, so the result of a request appears one clock after it is presented. A small controller holds one of three states. `ST_FLOAT` means all lanes are undriven. `ST_BYTE` means lanes 0..7 are driven. `ST_WORD` means lanes 0..15 are driven. On each clock the controller moves to `ST_FLOAT` if the chip is not selected or the output enable is inactive. Otherwise it moves to `ST_WORD` if word mode is set, or to `ST_BYTE` if it is not. Every state can reach every other state in one cycle. The array contents are computed when the block is built, and the polarity of the output enable is a build option.

Top module: `dwrom_top`

## Requirements
- R1: While reset is asserted, `data_o` and `data_oe_o` are all zero.
- R2: With `word_mode_i`=1, chip enable active (`chip_en_n_i`=0) and output enable active, one clock after the edge that samples the request, `data_o` holds the word at `addr_i` and `data_oe_o` equals 16'hFFFF.
- R3: With `word_mode_i`=0 and the chip selected and enabled, the byte address is {`addr_i`, `shared_lsb_i`}. A value of 0 on `shared_lsb_i` returns bits 7:0 of the stored word and 1 returns bits 15:8. The byte appears on `data_o[7:0]` one clock later, with `data_oe_o` equal to 16'h00FF.
- R4: In byte mode, lanes 14:8 are never enabled and read as zero.
- R5: Lane 15, the shared pad, is never enabled when the request was in byte mode, whatever the chip-enable and output-enable inputs are.
- R6: If `chip_en_n_i` is 1, then one clock later every bit of `data_oe_o` is 0, for any output-enable level and any mode.
- R7: Parameter `OE_POL` sets how the output enable is read. `OE_ACT_HIGH` (0) enables on `out_en_i`=1, `OE_ACT_LOW` (1) enables on `out_en_i`=0, and `OE_IGNORED` (2) treats the output enable as always active.
- R8: Any lane whose drive-enable bit is 0 reads 0 on `data_o`.
- R9: The word stored at index i is (i * 16'h9E37 + `SEED`) mod 2^16, with `SEED` defaulting to 16'h3C5A, for every index from 0 to 2^`ADDR_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode_i | input | 1 | 1 = 16-bit word reads, 0 = 8-bit byte reads |
| addr_i | input | ADDR_W | Word address, or the upper byte-address bits in byte mode |
| shared_lsb_i | input | 1 | Byte-address LSB (input side of the shared lane-15 pad) |
| chip_en_n_i | input | 1 | Chip enable, active low |
| out_en_i | input | 1 | Output enable, read as `OE_POL` sets |
| data_o | output | 16 | Read data; lane 15 is the output side of the shared pad |
| data_oe_o | output | 16 | Per-lane drive enable; 0 means high impedance |

## Verification
On every cycle the assertions check the lane enables against the request one clock earlier. They confirm that a deselected chip floats every lane, that byte mode never enables lanes 14..15, that a selected word read enables all lanes, and that undriven lanes read zero. They do not check data values. The bench's scenarios show those: the words and bytes returned for many addresses, the choice of byte half by the LSB input, back-to-back switches between modes, and the behaviour of all three output-enable polarities side by side under the same stimulus.

// File: rtl/dwrom_pkg.sv
package dwrom_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OE_ACT_HIGH = 2'd0,
        OE_ACT_LOW  = 2'd1,
        OE_IGNORED  = 2'd2
    } oe_pol_e;

    typedef enum logic [1:0] {
        ST_FLOAT = 2'd0,
        ST_BYTE  = 2'd1,
        ST_WORD  = 2'd2
    } lane_st_e;

    // Stored word for an index: a multiplicative hash plus a seed.
    function automatic logic [DATA_W-1:0] rom_word(input logic [31:0] idx,
                                                   input logic [DATA_W-1:0] seed);
        logic [31:0] prod;
        prod = idx * 32'h0000_9E37;
        return prod[DATA_W-1:0] + seed;
    endfunction

endpackage

// File: rtl/dwrom_array.sv
module dwrom_array
    import dwrom_pkg::*;
#(
    parameter int                ADDR_W = 6,
    parameter logic [DATA_W-1:0] SEED   = 16'h3C5A
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rom_q [DEPTH];

    // Contents are constants computed at elaboration (R9).
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign rom_q[g] = rom_word(32'(g), SEED);
    end

    assign word_o = rom_q[addr_i];

endmodule

// File: rtl/dwrom_ctrl.sv
module dwrom_ctrl
    import dwrom_pkg::*;
#(
    parameter oe_pol_e OE_POL = OE_ACT_LOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode_i,
    input  logic              chip_en_n_i,
    input  logic              out_en_i,
    output lane_st_e          st_d_o,
    output logic [DATA_W-1:0] lane_en_o
);
    logic     oe_active;
    lane_st_e st_q;
    lane_st_e st_d;

    // Output-enable polarity variant chosen at build time (R7).
    if (OE_POL == OE_ACT_HIGH) begin : g_oe_high
        assign oe_active = out_en_i;
    end else if (OE_POL == OE_ACT_LOW) begin : g_oe_low
        assign oe_active = ~out_en_i;
    end else begin : g_oe_ignored
        assign oe_active = 1'b1;
    end

    // Next state: FLOAT unless selected; then width by mode.
    always_comb begin
        if (chip_en_n_i || !oe_active) begin
            st_d = ST_FLOAT;
        end else if (word_mode_i) begin
            st_d = ST_WORD;
        end else begin
            st_d = ST_BYTE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_FLOAT;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs: lane enables per state.
    always_comb begin
        unique case (st_q)
            ST_FLOAT: lane_en_o = '0;
            ST_BYTE:  lane_en_o = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            ST_WORD:  lane_en_o = '1;
            default:  lane_en_o = '0;
        endcase
    end

    assign st_d_o = st_d;

    // Shared pad is never enabled outside ST_WORD (R5).
    p_pad_only_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_WORD) |-> !lane_en_o[DATA_W-1]);

endmodule

// File: rtl/dwrom_lane.sv
module dwrom_lane
    import dwrom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lane_st_e          st_d_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              lsb_i,
    output logic [DATA_W-1:0] data_o
);
    logic [BYTE_W-1:0] byte_sel;
    logic [DATA_W-1:0] data_d;
    logic [DATA_W-1:0] data_q;

    assign byte_sel = lsb_i ? word_i[DATA_W-1:BYTE_W] : word_i[BYTE_W-1:0];

    always_comb begin
        unique case (st_d_i)
            ST_WORD:  data_d = word_i;
            ST_BYTE:  data_d = {{(DATA_W-BYTE_W){1'b0}}, byte_sel};
            ST_FLOAT: data_d = '0;
            default:  data_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/dwrom_top.sv
module dwrom_top
    import dwrom_pkg::*;
#(
    parameter int                ADDR_W = 6,
    parameter logic [DATA_W-1:0] SEED   = 16'h3C5A,
    parameter oe_pol_e           OE_POL = OE_ACT_LOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              shared_lsb_i,
    input  logic              chip_en_n_i,
    input  logic              out_en_i,
    output logic [15:0]       data_o,
    output logic [15:0]       data_oe_o
);
    logic [DATA_W-1:0] word_w;
    lane_st_e          st_d_w;

    dwrom_array #(.ADDR_W(ADDR_W), .SEED(SEED)) u_array (
        .addr_i (addr_i),
        .word_o (word_w)
    );

    dwrom_ctrl #(.OE_POL(OE_POL)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_mode_i (word_mode_i),
        .chip_en_n_i (chip_en_n_i),
        .out_en_i    (out_en_i),
        .st_d_o      (st_d_w),
        .lane_en_o   (data_oe_o)
    );

    dwrom_lane u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_d_i (st_d_w),
        .word_i (word_w),
        .lsb_i  (shared_lsb_i),
        .data_o (data_o)
    );

    // Checker-side view of the enable level, from the port and parameter.
    logic chk_oe_on;
    always_comb begin
        case (OE_POL)
            OE_ACT_HIGH: chk_oe_on = out_en_i;
            OE_ACT_LOW:  chk_oe_on = !out_en_i;
            default:     chk_oe_on = 1'b1;
        endcase
    end

    p_ce_floats_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(chip_en_n_i)) |-> (data_oe_o == '0));

    p_byte_upper_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!word_mode_i)) |-> (data_oe_o[14:8] == '0));

    p_shared_pad_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!word_mode_i)) |-> !data_oe_o[15]);

    p_word_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_mode_i && !chip_en_n_i && chk_oe_on))
        |-> (data_oe_o == 16'hFFFF));

    p_polarity_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chk_oe_on)) |-> (data_oe_o == '0));

    p_undriven_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o & ~data_oe_o) == '0);

endmodule

// File: tb/sim_dwrom_top.sv
module sim_dwrom_top;
    import dwrom_pkg::*;

    localparam int AW = 6;
    localparam logic [15:0] SEED = 16'h3C5A;

    typedef struct {
        logic [15:0] d [3];
        logic [15:0] e [3];
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_mode = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          lsb = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe = 1'b0;
    logic [15:0]   d0, d1, d2, e0, e1, e2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    dwrom_top #(.ADDR_W(AW), .SEED(SEED), .OE_POL(OE_ACT_LOW)) u0 (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .addr_i(addr),
        .shared_lsb_i(lsb), .chip_en_n_i(ce_n), .out_en_i(oe),
        .data_o(d0), .data_oe_o(e0));
    dwrom_top #(.ADDR_W(AW), .SEED(SEED), .OE_POL(OE_ACT_HIGH)) u1 (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .addr_i(addr),
        .shared_lsb_i(lsb), .chip_en_n_i(ce_n), .out_en_i(oe),
        .data_o(d1), .data_oe_o(e1));
    dwrom_top #(.ADDR_W(AW), .SEED(SEED), .OE_POL(OE_IGNORED)) u2 (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .addr_i(addr),
        .shared_lsb_i(lsb), .chip_en_n_i(ce_n), .out_en_i(oe),
        .data_o(d2), .data_oe_o(e2));

    function automatic logic [15:0] model_word(int idx);
        logic [31:0] p;
        p = idx * 32'h9E37;
        return p[15:0] + SEED;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one request and push what it must yield.
    task automatic drive(bit wm, int a, bit l, bit cen, bit o, string tag);
        exp_t it;
        logic [15:0] w;
        bit act;
        @(negedge clk);
        word_mode = wm; addr = AW'(a); lsb = l; ce_n = cen; oe = o;
        w = model_word(a);
        for (int k = 0; k < 3; k++) begin
            act = (k == 0) ? !o : (k == 1) ? o : 1'b1;
            if (!act || cen) begin
                it.d[k] = 16'h0000; it.e[k] = 16'h0000;
            end else if (wm) begin
                it.d[k] = w; it.e[k] = 16'hFFFF;
            end else begin
                it.d[k] = {8'h00, l ? w[15:8] : w[7:0]}; it.e[k] = 16'h00FF;
            end
        end
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare each result one edge after its request.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                logic [15:0] ad [3];
                logic [15:0] ae [3];
                it = q.pop_front();
                ad[0] = d0; ad[1] = d1; ad[2] = d2;
                ae[0] = e0; ae[1] = e1; ae[2] = e2;
                for (int k = 0; k < 3; k++) begin
                    check(it.tag, ad[k], it.d[k], $sformatf("data u%0d", k));
                    check(it.tag, ae[k], it.e[k], $sformatf("enable u%0d", k));
                    if (it.e[k] == 16'h00FF) begin
                        check("R4", {8'h00, ad[k][15:8]}, 16'h0000, "upper lanes in byte mode");
                        check("R5", {15'h0, ae[k][15]}, 16'h0000, "shared pad enable");
                    end
                    if (it.e[k] == 16'h0000)
                        check("R8", ad[k], 16'h0000, "undriven lanes read");
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything quiet even with a live request.
        word_mode = 1'b1; ce_n = 1'b0; oe = 1'b0; addr = AW'(5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", d0, 16'h0, "data in reset");
        check("R1", e0, 16'h0, "enable in reset");
        check("R1", d2, 16'h0, "data in reset u2");
        check("R1", e2, 16'h0, "enable in reset u2");
        ce_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R9: every word address in word mode.
        for (int a = 0; a < (1 << AW); a++) drive(1, a, 0, 0, 0, "R9");
        drive(1, 0, 1, 0, 0, "R2");
        drive(1, (1 << AW) - 1, 1, 0, 0, "R2");

        // R3: both halves at several addresses, lsb toggling each cycle.
        for (int a = 0; a < 12; a++) drive(0, a * 5, a[0], 0, 0, "R3");
        drive(0, (1 << AW) - 1, 0, 0, 0, "R3");
        drive(0, (1 << AW) - 1, 1, 0, 0, "R3");

        // Mode switching back to back.
        for (int a = 0; a < 8; a++) drive(a[0], 17 + a, a[1], 0, 0, "R3");

        // R6: deselected in both modes, with either enable level.
        drive(1, 9, 0, 1, 0, "R6");
        drive(1, 9, 0, 1, 1, "R6");
        drive(0, 9, 1, 1, 0, "R6");
        drive(0, 9, 1, 1, 1, "R6");
        drive(1, 9, 0, 0, 0, "R2");

        // R7: enable level sweep; the three polarities react differently.
        for (int a = 0; a < 8; a++) drive(a[1], 30 + a, a[2], 0, a[0], "R7");

        repeat (3) drive(1, 3, 0, 1, 1, "R6");
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule